// File: doc/BRIEF.md
# Selectable Dynamic Key Generator

This block supplies a 64-bit cipher key from one of four sources, chosen by a 2-bit select input. Three sources are:

- the user key, passed through as it is;
- the two's complement of the user key;
- a 64-bit linear feedback shift register that is seeded from the user key and steps once per advance strobe.

The fourth source is a chaotic-map generator. It runs on every clock, starts from a fixed state and never reads the user key.

All four candidates go to a single output register. A key consumer sees the selected source one clock after the inputs that produce it. A valid flag tells the consumer when a user key has been loaded at least once since reset.

Top module: `dyn_key_gen`

## Requirements
- R1: While reset is asserted and until the first clock edge after it is released, key_o is 0 and valid_o is 0.
- R2: With sel_i = 0 at a clock edge, key_o after that edge equals key_i sampled at that edge.
- R3: With sel_i = 3, key_o after the edge equals (~key_i + 1) mod 2^64, so key_i = 0 gives 0, and 2^63 gives 2^63.
- R4: The shift register resets to 1. A load_i pulse copies key_i into it, or copies 1 if key_i is zero. A load takes priority over adv_i in the same cycle.
- R5: Each cycle with adv_i high and load_i low shifts the register right by one. Its new bit 63 is the XOR of the current bits 0, 1, 3 and 4 (polynomial x^64+x^63+x^61+x^60+1). With neither strobe high, it holds. With sel_i = 1, key_o after the edge equals the register value before that edge.
- R6: The chaotic state x is a 64-bit fraction of 2^64 that resets to 0x9E3779B97F4A7C15. On every clock it becomes (4·u) mod 1 with its lowest bit XORed with a dither bit. Here u = x when x < 0.5 and u = 1 − x otherwise. With sel_i = 2, key_o after the edge equals the state before that edge.
- R7: The dither bit is bit 0 of a 16-bit shift register. That register resets to 0xACE1 and shifts right on every clock. Its new bit 15 is bit 0 XOR bit 2 XOR bit 3 XOR bit 5. The chaotic sequence is unaffected by key_i, load_i and adv_i.
- R8: valid_o goes high after the first edge at which load_i is high, and stays high until reset.
- R9: A change of sel_i alone reaches key_o one clock later, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load user key into the shift-register source |
| key_i | input | 64 | User key |
| sel_i | input | 2 | Source select: 0 user, 1 shift register, 2 chaotic, 3 two's complement |
| adv_i | input | 1 | Step the shift-register source |
| key_o | output | 64 | Registered selected key |
| valid_o | output | 1 | A user key has been loaded since reset |

## Verification
A wrong shift-register or chaotic state does not show at once. It reaches key_o only when that source is selected, so the bench selects each source often, and it always shows one clock after selection. Because the chaotic state is multiplied by four each step, a single wrong bit is soon spread over the whole word. The dither register's error enters through bit 0 and shows within a few cycles of chaotic selection. A cycle-exact reference model compares key_o and valid_o on every clock, both over directed cases and over a long stretch of random inputs.

// File: rtl/dkg_pkg.sv
package dkg_pkg;
  typedef enum logic [1:0] {
    SRC_USER  = 2'd0,
    SRC_SHIFT = 2'd1,
    SRC_CHAOS = 2'd2,
    SRC_NEG   = 2'd3
  } key_src_e;

  localparam int unsigned KEY_W_DEF     = 64;
  localparam int unsigned DITH_W_DEF    = 16;
  localparam logic [63:0] KEY_TAPS_DEF  = 64'h0000_0000_0000_001B;
  localparam logic [63:0] KEY_SEED_DEF  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] CHAOS_INIT_DEF = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [15:0] DITH_TAPS_DEF = 16'h002D;
  localparam logic [15:0] DITH_SEED_DEF = 16'hACE1;
endpackage

// File: rtl/dkg_lfsr.sv
module dkg_lfsr #(
  parameter int unsigned W    = 64,
  parameter logic [W-1:0] TAPS = '0,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = (seed_i == '0) ? SEED : seed_i;
    else if (adv_i)  state_d = {fb, state_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dkg_chaos.sv
module dkg_chaos #(
  parameter int unsigned W      = 64,
  parameter logic [W-1:0] INIT  = 1,
  parameter int unsigned DW     = 16,
  parameter logic [DW-1:0] DTAPS = 16'h002D,
  parameter logic [DW-1:0] DSEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] QTR = {2'b01, {(W-2){1'b0}}};

  logic [DW-1:0] dith;
  logic [W-1:0]  x_q, m, x_d;

  dkg_lfsr #(.W(DW), .TAPS(DTAPS), .SEED(DSEED)) u_dith (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (1'b0),
    .seed_i  ({DW{1'b0}}),
    .adv_i   (1'b1),
    .state_o (dith)
  );

  // Fold the upper half onto the lower, remove the quarter offset; the
  // caller then scales by four.
  always_comb begin
    unique case (x_q[W-1:W-2])
      2'b00:   m = x_q;
      2'b01:   m = x_q - QTR;
      default: m = ~x_q + 1'b1;
    endcase
    x_d = {m[W-3:0], 2'b00};
    x_d[0] = x_d[0] ^ dith[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_q <= INIT;
    else         x_q <= x_d;
  end

  assign state_o = x_q;
endmodule

// File: rtl/dkg_neg.sv
module dkg_neg #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  assign y_o = ~a_i + {{(W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/dyn_key_gen.sv
module dyn_key_gen
  import dkg_pkg::*;
#(
  parameter int unsigned KEY_W        = KEY_W_DEF,
  parameter logic [KEY_W-1:0] TAPS    = KEY_TAPS_DEF,
  parameter logic [KEY_W-1:0] SEED    = KEY_SEED_DEF,
  parameter logic [KEY_W-1:0] C_INIT  = CHAOS_INIT_DEF,
  parameter int unsigned DITH_W       = DITH_W_DEF,
  parameter logic [DITH_W-1:0] D_TAPS = DITH_TAPS_DEF,
  parameter logic [DITH_W-1:0] D_SEED = DITH_SEED_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [1:0]       sel_i,
  input  logic             adv_i,
  output logic [KEY_W-1:0] key_o,
  output logic             valid_o
);
  logic [KEY_W-1:0] lfsr_q, chaos_q, neg_key, key_d, key_q;
  logic             valid_q;

  dkg_lfsr #(.W(KEY_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (key_i),
    .adv_i   (adv_i),
    .state_o (lfsr_q)
  );

  dkg_chaos #(.W(KEY_W), .INIT(C_INIT), .DW(DITH_W), .DTAPS(D_TAPS), .DSEED(D_SEED)) u_chaos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (chaos_q)
  );

  dkg_neg #(.W(KEY_W)) u_neg (
    .a_i (key_i),
    .y_o (neg_key)
  );

  always_comb begin
    unique case (key_src_e'(sel_i))
      SRC_USER:  key_d = key_i;
      SRC_SHIFT: key_d = lfsr_q;
      SRC_CHAOS: key_d = chaos_q;
      default:   key_d = neg_key;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      key_q <= key_d;
      if (load_i) valid_q <= 1'b1;
    end
  end

  assign key_o   = key_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dkg_checker.sv
module dkg_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic         adv_i,
  input logic [1:0]   sel_i,
  input logic [W-1:0] key_i,
  input logic [W-1:0] key_o,
  input logic         valid_o,
  input logic [W-1:0] lfsr_q
);
  p_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0) |=> (key_o == $past(key_i)));

  p_twos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd3) |=> ((key_o + $past(key_i)) == '0));

  p_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(lfsr_q));

  p_shift_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1) |=> (key_o == $past(lfsr_q)));

  p_valid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(load_i));
endmodule

bind dyn_key_gen dkg_checker #(.W(KEY_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .adv_i   (adv_i),
  .sel_i   (sel_i),
  .key_i   (key_i),
  .key_o   (key_o),
  .valid_o (valid_o),
  .lfsr_q  (lfsr_q)
);

// File: tb/dyn_key_gen_test.sv
module dyn_key_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, adv = 1'b0;
  logic [63:0] key = '0;
  logic [1:0]  sel = '0;
  logic [63:0] key_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  bit running = 0;

  // reference state
  logic [63:0] m_key, m_shift, m_chaos;
  logic [15:0] m_dith;
  logic        m_valid;
  logic [1:0]  m_prev_sel;
  string       m_tag;

  always #4 clk = ~clk;

  dyn_key_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .key_i(key),
    .sel_i(sel), .adv_i(adv), .key_o(key_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key = '0; m_valid = 0; m_shift = 64'd1;
      m_chaos = 64'h9E3779B97F4A7C15; m_dith = 16'hACE1;
      m_prev_sel = '0; m_tag = "R1";
    end else begin
      logic [63:0] nx; logic fb;
      case (sel)
        2'd0: begin m_key = key;          m_tag = "R2"; end
        2'd1: begin m_key = m_shift;      m_tag = "R5"; end
        2'd2: begin m_key = m_chaos;      m_tag = "R6 R7"; end
        default: begin m_key = 64'd0 - key; m_tag = "R3"; end
      endcase
      if (sel != m_prev_sel) m_tag = {m_tag, " R9"};
      m_prev_sel = sel;
      if (load) m_valid = 1;
      // R4 / R5 shift source
      if (load) m_shift = (key == 0) ? 64'd1 : key;
      else if (adv) begin
        fb = m_shift[0] ^ m_shift[1] ^ m_shift[3] ^ m_shift[4];
        m_shift = (m_shift >> 1) | ({63'd0, fb} << 63);
      end
      // R6 chaotic map, R7 dither
      nx = m_chaos[63] ? (64'd0 - m_chaos) * 64'd4 : m_chaos * 64'd4;
      nx[0] = nx[0] ^ m_dith[0];
      m_chaos = nx;
      fb = m_dith[0] ^ m_dith[2] ^ m_dith[3] ^ m_dith[5];
      m_dith = {fb, m_dith[15:1]};
    end
  end

  always @(negedge clk) if (running) begin
    chk(key_o === m_key, m_tag, key_o, m_key);
    chk(valid_o === m_valid, "R8", {63'd0, valid_o}, {63'd0, m_valid});
  end

  task automatic drive(input bit l, input logic [63:0] k, input logic [1:0] s, input bit a);
    @(negedge clk);
    load = l; key = k; sel = s; adv = a;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(key_o === 64'd0 && valid_o === 1'b0, "R1", key_o, 64'd0);
    rst_n = 1'b1;
    running = 1;
    drive(0, 64'h1234, 2'd2, 0);       // R7 chaos runs before any load
    repeat (5) drive(0, 64'hFFFF_0000_1234_5678, 2'd2, 1);
    drive(1, 64'h0E329232EA6D0D73, 2'd0, 0);
    drive(0, 64'h0E329232EA6D0D73, 2'd3, 0);
    drive(0, 64'd0, 2'd3, 0);          // R3 zero
    drive(0, 64'h8000_0000_0000_0000, 2'd3, 0);
    drive(0, 64'd1, 2'd3, 0);
    drive(0, 64'd5, 2'd1, 0);          // R5 hold
    repeat (6) drive(0, 64'd5, 2'd1, 1);
    drive(1, 64'd0, 2'd1, 0);          // R4 zero seed
    drive(0, 64'd0, 2'd1, 0);
    @(posedge clk); #1;
    chk(key_o === 64'd1, "R4", key_o, 64'd1);
    drive(1, 64'hDEAD_BEEF_0000_0001, 2'd1, 1);   // R4 load beats advance
    drive(0, 64'd0, 2'd1, 0);
    for (int i = 0; i < 8; i++) drive(0, 64'(i), 2'(i), 0);  // R9 select sweep
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 16) == 0, {$urandom, $urandom}, 2'($urandom), $urandom % 2);
    drive(0, 64'd0, 2'd0, 0);
    @(negedge clk);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule